// File: doc/BRIEF.md
# Per-Target Priority Claim Arbiter

This block sits between the per-source interrupt gateways and the interrupt targets of a platform interrupt controller. Every clock, and for every target separately, it looks at the sources that are pending, enabled for that target and whose priority lies strictly above the target's threshold. From that set it picks one winner: the highest priority, with the lowest source number breaking ties. It presents the winner's identifier and an interrupt line per target. Identifier 0 is reserved and means "nothing to service"; source bit i is reported as identifier i+1.

Targets talk back with single-cycle pulses. A claim pulse takes the identifier the target currently sees and forwards a one-hot pulse to that source's gateway. The source is struck from every target's candidate set in that same cycle, so no second target can be handed it. A completion pulse is forwarded to the source that the same target claimed most recently. Register decoding and pending-event counting live outside this block.

Top module: `prio_claim_arb`

## Requirements
- R1: Source bit i (0-based) is reported as identifier i+1 in the IDW = clog2(N_SRC+1) bit field `id_o[t*IDW +: IDW]` of target t. Identifier 0 is reported when target t has no candidate.
- R2: Among the candidates of a target, the source with the numerically largest priority is chosen. Source i's priority is `prio_i[i*PW +: PW]`, with PW = clog2(PRIO_LEVELS+1).
- R3: When several candidates share the largest priority, the one with the lowest source number wins.
- R4: A source is a candidate for target t only if its pending bit is 1 and `enable_i[t*N_SRC + i]` is 1.
- R5: With THRESH_EN=1, a source is a candidate for target t only if its priority is strictly greater than `thresh_i[t*PW +: PW]`. A threshold of 0 masks no source whose priority is nonzero.
- R6: A source with priority 0 is never a candidate, whatever the threshold.
- R7: `id_o` and `irq_o` are registered. A change on the inputs becomes visible after exactly one rising clock edge.
- R8: `irq_o[t]` is 1 exactly when target t's identifier is nonzero. After a claim, it falls unless another candidate remains.
- R9: A claim pulse `claim_i[t]` drives, in the same cycle, a one-hot `claim_src_o` on the bit of the source whose identifier target t currently sees. A claim while the identifier is 0 forwards nothing.
- R10: A source claimed in a cycle is excluded from the selection of every target at that clock edge, even if its pending bit stays high.
- R11: `complete_i[t]` drives, in the same cycle, `complete_src_o` on the bit of the last source that target t claimed with a nonzero identifier. If target t has never claimed, it forwards nothing. A claim returning 0 leaves the remembered source unchanged.
- R12: Synchronous active-high reset forces all identifiers to 0, all interrupt lines low and all remembered claims to none.
- R13: With THRESH_EN=0, thresholds have no effect and any enabled, pending source of nonzero priority is a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | N_SRC | Pending request per source |
| prio_i | input | N_SRC*PW | Priority per source, packed fields |
| enable_i | input | N_TGT*N_SRC | Enable matrix, one N_SRC slice per target |
| thresh_i | input | N_TGT*PW | Threshold per target |
| claim_i | input | N_TGT | Claim pulse per target |
| complete_i | input | N_TGT | Completion pulse per target |
| id_o | output | N_TGT*IDW | Presented winning identifier per target |
| irq_o | output | N_TGT | Interrupt line per target |
| claim_src_o | output | N_SRC | Claim pulse forwarded to source gateways |
| complete_src_o | output | N_SRC | Completion pulse forwarded to source gateways |

## Verification
Any corrupted selection state reaches the ports within one clock edge, as a wrong identifier or a wrong interrupt level. A wrong remembered claim shows only when the owning target next completes, so the bench completes after interleaved claims from both targets and after a claim that returned 0. The selection is swept across every combination of pending and priority patterns on a small configuration, with varied enables and thresholds, and both threshold variants run side by side against an arithmetic model.

// File: rtl/pca_pkg.sv
package pca_pkg;

    // Identifier width: one code per source plus the reserved "none" code 0.
    function automatic int unsigned id_bits(input int unsigned n_src);
        return $clog2(n_src + 1);
    endfunction

    // Priority field width able to hold levels 0..levels.
    function automatic int unsigned prio_bits(input int unsigned levels);
        return (levels < 1) ? 1 : $clog2(levels + 1);
    endfunction

    // Threshold comparison variant.
    typedef enum logic {
        THR_IGNORED = 1'b0,
        THR_STRICT  = 1'b1
    } thr_mode_e;

endpackage

// File: rtl/pca_candidates.sv
module pca_candidates #(
    parameter int unsigned N_SRC     = 16,
    parameter int unsigned PW        = 3,
    parameter int unsigned THRESH_EN = 1
) (
    input  logic [N_SRC-1:0]    pend_i,
    input  logic [N_SRC-1:0]    block_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    input  logic [N_SRC-1:0]    en_i,
    input  logic [PW-1:0]       thr_i,
    output logic [N_SRC-1:0]    cand_o
);
    import pca_pkg::*;

    localparam thr_mode_e MODE = (THRESH_EN != 0) ? THR_STRICT : THR_IGNORED;

    logic [N_SRC-1:0] above;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (MODE == THR_STRICT) begin : g_thr
            // strictly above threshold also excludes priority 0
            assign above[i] = prio_i[i*PW +: PW] > thr_i;
        end else begin : g_nothr
            assign above[i] = prio_i[i*PW +: PW] != '0;
        end
        assign cand_o[i] = pend_i[i] & ~block_i[i] & en_i[i] & above[i];
    end

endmodule

// File: rtl/pca_select.sv
module pca_select #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned PW    = 3,
    parameter int unsigned IDW   = 5
) (
    input  logic [N_SRC-1:0]    cand_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    output logic                hit_o,
    output logic [IDW-1:0]      id_o,
    output logic [PW-1:0]       prio_o
);
    // Ascending scan with a strict compare: an equal priority found later
    // never displaces an earlier (lower numbered) winner.
    always_comb begin
        hit_o  = 1'b0;
        id_o   = '0;
        prio_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] && (!hit_o || prio_i[i*PW +: PW] > prio_o)) begin
                hit_o  = 1'b1;
                prio_o = prio_i[i*PW +: PW];
                id_o   = IDW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/pca_router.sv
module pca_router #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned N_TGT = 4,
    parameter int unsigned IDW   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_TGT-1:0]     claim_i,
    input  logic [N_TGT-1:0]     complete_i,
    input  logic [N_TGT*IDW-1:0] id_i,
    output logic [N_SRC-1:0]     claim_src_o,
    output logic [N_SRC-1:0]     complete_src_o
);
    logic [IDW-1:0] cur_id [N_TGT];
    logic [IDW-1:0] last_q [N_TGT];

    for (genvar t = 0; t < N_TGT; t++) begin : g_unpack
        assign cur_id[t] = id_i[t*IDW +: IDW];
    end

    always_comb begin
        claim_src_o    = '0;
        complete_src_o = '0;
        for (int t = 0; t < N_TGT; t++) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (claim_i[t] && cur_id[t] == IDW'(s + 1)) claim_src_o[s] = 1'b1;
                if (complete_i[t] && last_q[t] == IDW'(s + 1)) complete_src_o[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < N_TGT; t++) last_q[t] <= '0;
        end else begin
            for (int t = 0; t < N_TGT; t++) begin
                if (claim_i[t] && cur_id[t] != '0) last_q[t] <= cur_id[t];
            end
        end
    end

    // R9: a lone claim forwards at most one source pulse
    a_r9_claim_onehot : assert property (@(posedge clk) disable iff (rst)
        ($countones(claim_i) <= 1) |-> $onehot0(claim_src_o));

    // R11: no completion reaches a gateway without a target pulse
    a_r11_complete_needs_pulse : assert property (@(posedge clk) disable iff (rst)
        (complete_src_o != '0) |-> (complete_i != '0));

endmodule

// File: rtl/prio_claim_arb.sv
module prio_claim_arb #(
    parameter int unsigned N_SRC       = 16,
    parameter int unsigned N_TGT       = 4,
    parameter int unsigned PRIO_LEVELS = 7,
    parameter int unsigned THRESH_EN   = 1,
    localparam int unsigned IDW        = pca_pkg::id_bits(N_SRC),
    localparam int unsigned PW         = pca_pkg::prio_bits(PRIO_LEVELS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC-1:0]       pend_i,
    input  logic [N_SRC*PW-1:0]    prio_i,
    input  logic [N_TGT*N_SRC-1:0] enable_i,
    input  logic [N_TGT*PW-1:0]    thresh_i,
    input  logic [N_TGT-1:0]       claim_i,
    input  logic [N_TGT-1:0]       complete_i,
    output logic [N_TGT*IDW-1:0]   id_o,
    output logic [N_TGT-1:0]       irq_o,
    output logic [N_SRC-1:0]       claim_src_o,
    output logic [N_SRC-1:0]       complete_src_o
);
    typedef struct packed {
        logic           hit;
        logic [IDW-1:0] id;
    } pick_t;

    logic [N_SRC-1:0] claim_src;
    logic [N_SRC-1:0] cand     [N_TGT];
    pick_t            pick     [N_TGT];
    logic [PW-1:0]    win_prio [N_TGT];
    pick_t            pick_q   [N_TGT];

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        pca_candidates #(
            .N_SRC     (N_SRC),
            .PW        (PW),
            .THRESH_EN (THRESH_EN)
        ) u_cand (
            .pend_i  (pend_i),
            .block_i (claim_src),
            .prio_i  (prio_i),
            .en_i    (enable_i[t*N_SRC +: N_SRC]),
            .thr_i   (thresh_i[t*PW +: PW]),
            .cand_o  (cand[t])
        );

        pca_select #(
            .N_SRC (N_SRC),
            .PW    (PW),
            .IDW   (IDW)
        ) u_sel (
            .cand_i (cand[t]),
            .prio_i (prio_i),
            .hit_o  (pick[t].hit),
            .id_o   (pick[t].id),
            .prio_o (win_prio[t])
        );

        always_ff @(posedge clk) begin
            if (rst) pick_q[t] <= '0;
            else     pick_q[t] <= pick[t];
        end

        assign id_o[t*IDW +: IDW] = pick_q[t].id;
        assign irq_o[t]           = pick_q[t].hit;

        // Pairwise cross-check of the scan: no candidate may beat the winner.
        logic [N_SRC-1:0] beats;
        for (genvar s = 0; s < N_SRC; s++) begin : g_beat
            assign beats[s] = cand[t][s] &&
                (!pick[t].hit ||
                 prio_i[s*PW +: PW] > win_prio[t] ||
                 (prio_i[s*PW +: PW] == win_prio[t] && IDW'(s + 1) < pick[t].id));
        end

        // R2 and R3: winner is the top priority, lowest number on ties
        a_r3_no_better_candidate : assert property (@(posedge clk) disable iff (rst)
            beats == '0);

        // R1: presented identifier stays within the source range
        a_r1_id_in_range : assert property (@(posedge clk) disable iff (rst)
            id_o[t*IDW +: IDW] <= IDW'(N_SRC));

        // R10: a claimed identifier is not presented again at the next edge
        a_r10_claimed_id_moves : assert property (@(posedge clk) disable iff (rst)
            (claim_i[t] && id_o[t*IDW +: IDW] != '0) |=>
            (id_o[t*IDW +: IDW] != $past(id_o[t*IDW +: IDW])));

        // R8: a raised line implies some source was pending at the prior edge
        a_r8_irq_needs_pending : assert property (@(posedge clk) disable iff (rst)
            irq_o[t] |-> ($past(pend_i) != '0));
    end

    pca_router #(
        .N_SRC (N_SRC),
        .N_TGT (N_TGT),
        .IDW   (IDW)
    ) u_route (
        .clk            (clk),
        .rst            (rst),
        .claim_i        (claim_i),
        .complete_i     (complete_i),
        .id_i           (id_o),
        .claim_src_o    (claim_src),
        .complete_src_o (complete_src_o)
    );

    assign claim_src_o = claim_src;

    // R12: first cycle out of reset shows no interrupt
    a_r12_reset_quiet : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == '0));

endmodule

// File: tb/prio_claim_arb_tb.sv
module prio_claim_arb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NT = 2;
    localparam int PW = 2;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0]    pend  = '0;
    logic [NS*PW-1:0] prio  = '0;
    logic [NT*NS-1:0] en    = '0;
    logic [NT*PW-1:0] thr   = '0;
    logic [NT-1:0]    claim = '0;
    logic [NT-1:0]    comp  = '0;

    logic [NT*IW-1:0] id_a, id_b;
    logic [NT-1:0]    irq_a, irq_b;
    logic [NS-1:0]    cs_a, cc_a, cs_b, cc_b;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_claim_arb #(.N_SRC(NS), .N_TGT(NT), .PRIO_LEVELS(3), .THRESH_EN(1)) u_dut (
        .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .enable_i(en),
        .thresh_i(thr), .claim_i(claim), .complete_i(comp), .id_o(id_a),
        .irq_o(irq_a), .claim_src_o(cs_a), .complete_src_o(cc_a));

    prio_claim_arb #(.N_SRC(NS), .N_TGT(NT), .PRIO_LEVELS(3), .THRESH_EN(0)) u_dut_nt (
        .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .enable_i(en),
        .thresh_i(thr), .claim_i(claim), .complete_i(comp), .id_o(id_b),
        .irq_o(irq_b), .claim_src_o(cs_b), .complete_src_o(cc_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_id(input logic [NS-1:0] p, input logic [NS*PW-1:0] pr,
                                  input logic [NS-1:0] e, input logic [PW-1:0] th,
                                  input bit use_thr);
        int best = 0;
        int bp = 0;
        for (int i = 0; i < NS; i++) begin
            int pv;
            pv = int'(pr[i*PW +: PW]);
            if (p[i] && e[i] && pv > bp && (!use_thr || pv > int'(th))) begin
                best = i + 1;
                bp = pv;
            end
        end
        return best;
    endfunction

    function automatic int ida(input int t);
        return int'(id_a[t*IW +: IW]);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired (R7 run did not finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R12: reset holds outputs quiet even with live candidates
        pend = 4'b1111; prio = 8'hFF; en = 8'hFF; thr = '0;
        repeat (3) @(negedge clk);
        chk("R12 id t0 in reset", ida(0), 0);
        chk("R12 irq in reset", int'(irq_a), 0);
        pend = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 id after reset", int'(id_a), 0);

        // R1: single source maps to id i+1
        prio = 8'b01_01_01_01; pend = 4'b0001;
        @(negedge clk);
        chk("R1 source0 id", ida(0), 1);
        pend = 4'b1000;
        @(negedge clk);
        chk("R1 source3 id", ida(1), 4);

        // R7: old value until the next edge, new value after it
        pend = 4'b0010;
        #1;
        chk("R7 before edge", ida(0), 4);
        @(negedge clk);
        chk("R7 after edge", ida(0), 2);

        // R2: larger priority wins
        prio = 8'b11_00_00_01; pend = 4'b1001;
        @(negedge clk);
        chk("R2 higher priority", ida(0), 4);

        // R3: tie goes to lower number
        prio = 8'b00_10_10_00; pend = 4'b0110;
        @(negedge clk);
        chk("R3 tie lowest id", ida(1), 2);

        // R4: enable gating
        en = 8'b1111_0001;
        @(negedge clk);
        chk("R4 disabled sources t0", ida(0), 0);
        chk("R4 enabled t1", ida(1), 2);
        en = 8'hFF;

        // R5 / R13: strict threshold
        prio = 8'b00_10_00_00; pend = 4'b0100; thr = {2'd1, 2'd2};
        @(negedge clk);
        chk("R5 equal to threshold masked", ida(0), 0);
        chk("R5 above threshold", ida(1), 3);
        chk("R13 threshold ignored", int'(id_b[0 +: IW]), 3);
        thr = '0;

        // R6: priority 0 never notifies
        prio = '0; pend = 4'b1111;
        @(negedge clk);
        chk("R6 zero priority id", int'(id_a), 0);
        chk("R6 zero priority irq", int'(irq_a), 0);
        chk("R6 zero priority no threshold", int'(irq_b), 0);

        // R9 / R10: claim forwarding and exclusion
        prio = 8'b11_11_10_01; pend = 4'b1111;
        @(negedge clk);
        chk("R3 tie before claim", ida(0), 3);
        claim = 2'b01;
        #1;
        chk("R9 claim forwarded", int'(cs_a), 4'b0100);
        @(negedge clk);
        claim = '0;
        chk("R10 claimer moved", ida(0), 4);
        chk("R10 other target moved", ida(1), 4);
        chk("R8 irq stays with remaining", int'(irq_a), 2'b11);
        @(negedge clk);
        chk("R10 source back when still pending", ida(0), 3);

        // R11: completion routing
        comp = 2'b01;
        #1;
        chk("R11 complete to claimed", int'(cc_a), 4'b0100);
        comp = 2'b10;
        #1;
        chk("R11 no prior claim", int'(cc_a), 0);
        comp = '0;
        pend = 4'b0011;
        @(negedge clk);
        chk("R2 t1 sees source1", ida(1), 2);
        claim = 2'b10;
        #1;
        chk("R9 claim t1", int'(cs_a), 4'b0010);
        @(negedge clk);
        claim = '0;
        comp = 2'b01;
        #1;
        chk("R11 t0 keeps own claim", int'(cc_a), 4'b0100);
        comp = 2'b10;
        #1;
        chk("R11 t1 own claim", int'(cc_a), 4'b0010);
        comp = '0;

        // R9 / R11: claim of id 0
        pend = '0;
        @(negedge clk);
        claim = 2'b11;
        #1;
        chk("R9 empty claim", int'(cs_a), 0);
        @(negedge clk);
        claim = '0;
        comp = 2'b01;
        #1;
        chk("R11 empty claim keeps memory", int'(cc_a), 4'b0100);
        comp = '0;

        // R8: line falls after claiming the only candidate
        pend = 4'b0100;
        @(negedge clk);
        chk("R8 irq up", int'(irq_a[0]), 1);
        claim = 2'b01;
        @(negedge clk);
        claim = '0;
        chk("R8 irq drops", int'(irq_a[0]), 0);
        chk("R1 id zero when none", ida(0), 0);

        // Sweep: every pending and priority pattern, varied enables/thresholds
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] w;
            w = 12'(v);
            pend = w[3:0];
            prio = w[11:4];
            en   = {w[6:0], w[7]} ^ 8'hA5;
            thr  = {w[9:8], w[11:10]};
            @(negedge clk);
            for (int t = 0; t < NT; t++) begin
                int ea, eb;
                ea = ref_id(pend, prio, en[t*NS +: NS], thr[t*PW +: PW], 1'b1);
                eb = ref_id(pend, prio, en[t*NS +: NS], thr[t*PW +: PW], 1'b0);
                chk("R2/R3/R4/R5/R6 sweep id", ida(t), ea);
                chk("R8 sweep irq", int'(irq_a[t]), int'(ea != 0));
                chk("R13 sweep id", int'(id_b[t*IW +: IW]), eb);
                chk("R8 sweep irq no threshold", int'(irq_b[t]), int'(eb != 0));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule